// File: doc/BRIEF.md
# Peripheral Bus Address Window Router

This block sits between a host-side memory-mapped port and six targets on a peripheral bus. Each host request carries a byte address, a byte count and, for writes, data. The router keeps only the low 32 bits of the address. It finds the window that contains the address and raises that target's select line. It also passes the target an offset measured from the window's base.

Data on the bus is big-endian. A single-byte access is steered onto the lane that its address names, and a 32-bit access uses all four lanes. Targets answer combinationally in the request cycle. The router registers the reply and returns it to the host one clock later, with an error bit set for an access size it does not support or for an address outside every window.

The window map is fixed:

| Index | Window | Addresses |
|-------|--------|-----------|
| 0 | I/O space | 0xD0010000..0xD001FFFF |
| 1 | memory space | 0xE0010000..0xEFFFFFFF |
| 2 | firmware space | 0xF0000000..0xFFFFFFFF |
| 3 | bus master registers | 0xC0010000..0xC001005F |
| 4 | arbiter registers | 0xC0011000..0xC0011007 |
| 5 | host controller registers | 0xC0012000..0xC00120FF |

Top module: `opb_window_router`

## Requirements
- R1: Bits 63..32 of `host_addr` have no effect on decode, offset, lane choice or response; only bits 31..0 are used.
- R2: A request with a valid size and an address inside window i sets `tgt_sel` to the one-hot value with only bit i set, using the window index of the table above. With `host_req` low, `tgt_sel` is zero and `tgt_we` is low.
- R3: While a target is selected, `tgt_offset` equals the 32-bit address minus the base of that window.
- R4: `host_size` gives the access length in bytes, and only 1 and 4 are legal. Any other value selects no target and keeps `tgt_we` low, even when the address falls outside every window. One cycle later the router replies with `rsp_err`=1 and `rsp_rdata`=0.
- R5: A request of legal size whose address lies in no window selects no target. One cycle later the router replies with `rsp_err`=1 and `rsp_rdata`=0xFFFFFFFF.
- R6: For a byte write at address bits [1:0]=k, `tgt_bmask` has only bit 3-k set. `tgt_wdata` carries `host_wdata[7:0]` in bits [8*(3-k)+7 : 8*(3-k)], and all its other bits are zero. The byte at the lowest address is therefore the most significant lane.
- R7: A byte read at address bits [1:0]=k returns bits [8*(3-k)+7 : 8*(3-k)] of the selected target's read word in `rsp_rdata[7:0]`, with the upper 24 bits zero.
- R8: A 32-bit access sets `tgt_bmask`=4'b1111 and passes `host_wdata` through unchanged. A 32-bit read returns the selected target's whole word. A successful write returns `rsp_rdata`=0 and `rsp_err`=0.
- R9: `rsp_valid` is high exactly in the cycle after a cycle with `host_req` high. With no request, `rsp_err` and `rsp_rdata` are zero.
- R10: Reset clears `rsp_valid`, `rsp_err` and `rsp_rdata` to zero.
- R11: The last byte of each window decodes to that window, and the byte just past its end decodes to no window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Request valid for this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 64 | Host byte address; only bits 31..0 are decoded |
| host_size | input | 4 | Access length in bytes |
| host_wdata | input | 32 | Write data; a byte write uses bits 7..0 |
| tgt_sel | output | 6 | One-hot target select, indexed by window |
| tgt_we | output | 1 | Write strobe to the selected target |
| tgt_offset | output | 32 | Address relative to the selected window's base |
| tgt_bmask | output | 4 | Byte-lane enables; bit 3 is the lowest address |
| tgt_wdata | output | 32 | Lane-steered write data |
| tgt_rdata | input | 192 | Read words of all targets; target i in bits 32*i+31..32*i |
| rsp_valid | output | 1 | Reply valid, one cycle after the request |
| rsp_err | output | 1 | Reply error flag |
| rsp_rdata | output | 32 | Reply read data |

## Verification
Select, offset, byte mask and write data depend only on the current request, so they are due in the request cycle itself. Read data and the error flag pass through one register, so they are due exactly one clock later. The bench drives each request just after a rising edge and compares at the following falling edge. At that point it checks the target-side outputs against its model of the present request. It checks the reply against the expectation it stored at the previous falling edge, so every check lands in the cycle its result is due.

// File: rtl/opbr_pkg.sv
`timescale 1ns/1ps
package opbr_pkg;

    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int SIZE_W  = 4;
    localparam int NUM_WIN = 6;
    localparam int BYTES   = DATA_W / 8;
    localparam int LANE_W  = $clog2(BYTES);

    localparam logic [SIZE_W-1:0] SZ_BYTE = SIZE_W'(1);
    localparam logic [SIZE_W-1:0] SZ_WORD = SIZE_W'(BYTES);

    typedef enum logic [2:0] {
        WIN_IO      = 3'd0,
        WIN_MEM     = 3'd1,
        WIN_FW      = 3'd2,
        WIN_MASTER  = 3'd3,
        WIN_ARB     = 3'd4,
        WIN_HOSTCTL = 3'd5
    } win_e;

    typedef enum logic [1:0] {
        ACC_BYTE,
        ACC_WORD,
        ACC_BAD
    } acc_e;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    function automatic logic [ADDR_W-1:0] win_base(input int idx);
        logic [ADDR_W-1:0] b;
        case (idx)
            int'(WIN_IO):      b = 32'hD001_0000;
            int'(WIN_MEM):     b = 32'hE001_0000;
            int'(WIN_FW):      b = 32'hF000_0000;
            int'(WIN_MASTER):  b = 32'hC001_0000;
            int'(WIN_ARB):     b = 32'hC001_1000;
            int'(WIN_HOSTCTL): b = 32'hC001_2000;
            default:           b = '0;
        endcase
        return b;
    endfunction

    function automatic logic [ADDR_W-1:0] win_span(input int idx);
        logic [ADDR_W-1:0] s;
        case (idx)
            int'(WIN_IO):      s = 32'h0001_0000;
            int'(WIN_MEM):     s = 32'h0FFF_0000;
            int'(WIN_FW):      s = 32'h1000_0000;
            int'(WIN_MASTER):  s = 32'h0000_0060;
            int'(WIN_ARB):     s = 32'h0000_0008;
            int'(WIN_HOSTCTL): s = 32'h0000_0100;
            default:           s = '0;
        endcase
        return s;
    endfunction

    function automatic acc_e classify(input logic [SIZE_W-1:0] sz);
        if (sz == SZ_BYTE)      return ACC_BYTE;
        else if (sz == SZ_WORD) return ACC_WORD;
        else                    return ACC_BAD;
    endfunction

endpackage

// File: rtl/opbr_window_decode.sv
`timescale 1ns/1ps
module opbr_window_decode
    import opbr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NW = NUM_WIN
) (
    input  logic [AW-1:0] addr,
    output logic [NW-1:0] hit,
    output logic [AW-1:0] offset
);

    logic [AW-1:0] rel [NW];

    for (genvar gi = 0; gi < NW; gi++) begin : g_win
        localparam logic [AW-1:0] BASE = AW'(win_base(gi));
        localparam logic [AW-1:0] SPAN = AW'(win_span(gi));
        assign rel[gi] = addr - BASE;
        assign hit[gi] = (addr >= BASE) && (rel[gi] < SPAN);
    end

    always_comb begin
        offset = '0;
        for (int i = 0; i < NW; i++) begin
            if (hit[i]) offset = offset | rel[i];
        end
    end

endmodule

// File: rtl/opbr_lane_steer.sv
`timescale 1ns/1ps
module opbr_lane_steer
    import opbr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int BY = DW / 8,
    parameter int LW = $clog2(BY)
) (
    input  acc_e          acc,
    input  logic [LW-1:0] lane_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic [DW-1:0] word_in,
    output logic [BY-1:0] bmask,
    output logic [DW-1:0] wdata_out,
    output logic [DW-1:0] rdata_out
);

    logic [LW-1:0] lane;
    assign lane = LW'(BY - 1) - lane_addr;

    always_comb begin
        bmask     = '0;
        wdata_out = '0;
        rdata_out = '0;
        case (acc)
            ACC_BYTE: begin
                for (int b = 0; b < BY; b++) begin
                    if (b == int'(lane)) begin
                        bmask[b]          = 1'b1;
                        wdata_out[8*b+:8] = host_wdata[7:0];
                        rdata_out[7:0]    = word_in[8*b+:8];
                    end
                end
            end
            ACC_WORD: begin
                bmask     = '1;
                wdata_out = host_wdata;
                rdata_out = word_in;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/opbr_rsp_reg.sv
`timescale 1ns/1ps
module opbr_rsp_reg
    import opbr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  rsp_t nxt,
    output rsp_t cur
);

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

endmodule

// File: rtl/opb_window_router.sv
`timescale 1ns/1ps
module opb_window_router
    import opbr_pkg::*;
#(
    parameter int HOST_AW = 64
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      host_req,
    input  logic                      host_we,
    input  logic [HOST_AW-1:0]        host_addr,
    input  logic [SIZE_W-1:0]         host_size,
    input  logic [DATA_W-1:0]         host_wdata,
    output logic [NUM_WIN-1:0]        tgt_sel,
    output logic                      tgt_we,
    output logic [ADDR_W-1:0]         tgt_offset,
    output logic [BYTES-1:0]          tgt_bmask,
    output logic [DATA_W-1:0]         tgt_wdata,
    input  logic [NUM_WIN*DATA_W-1:0] tgt_rdata,
    output logic                      rsp_valid,
    output logic                      rsp_err,
    output logic [DATA_W-1:0]         rsp_rdata
);

    logic [ADDR_W-1:0]  bus_addr;
    logic               unused_upper;
    acc_e               acc;
    logic [NUM_WIN-1:0] hit;
    logic               any_hit;
    logic [DATA_W-1:0]  sel_word;
    logic [DATA_W-1:0]  steered_rd;
    rsp_t               rsp_nxt;
    rsp_t               rsp_cur;

    assign bus_addr     = host_addr[ADDR_W-1:0];
    assign unused_upper = ^host_addr[HOST_AW-1:ADDR_W];
    assign acc          = classify(host_size);
    assign any_hit      = |hit;

    opbr_window_decode #(
        .AW (ADDR_W),
        .NW (NUM_WIN)
    ) u_decode (
        .addr   (bus_addr),
        .hit    (hit),
        .offset (tgt_offset)
    );

    always_comb begin
        sel_word = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (hit[i]) sel_word = sel_word | tgt_rdata[DATA_W*i +: DATA_W];
        end
    end

    opbr_lane_steer #(
        .DW (DATA_W)
    ) u_steer (
        .acc        (acc),
        .lane_addr  (bus_addr[LANE_W-1:0]),
        .host_wdata (host_wdata),
        .word_in    (sel_word),
        .bmask      (tgt_bmask),
        .wdata_out  (tgt_wdata),
        .rdata_out  (steered_rd)
    );

    assign tgt_sel = (host_req && acc != ACC_BAD) ? hit : '0;
    assign tgt_we  = host_we && (|tgt_sel);

    always_comb begin
        rsp_nxt = '0;
        if (host_req) begin
            rsp_nxt.valid = 1'b1;
            if (acc == ACC_BAD) begin
                rsp_nxt.err   = 1'b1;
                rsp_nxt.rdata = '0;
            end else if (!any_hit) begin
                rsp_nxt.err   = 1'b1;
                rsp_nxt.rdata = '1;
            end else begin
                rsp_nxt.err   = 1'b0;
                rsp_nxt.rdata = host_we ? '0 : steered_rd;
            end
        end
    end

    opbr_rsp_reg u_rsp (
        .clk (clk),
        .rst (rst),
        .nxt (rsp_nxt),
        .cur (rsp_cur)
    );

    assign rsp_valid = rsp_cur.valid;
    assign rsp_err   = rsp_cur.err;
    assign rsp_rdata = rsp_cur.rdata;

endmodule

// File: rtl/opbr_checker.sv
`timescale 1ns/1ps
module opbr_checker
    import opbr_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               host_req,
    input logic [SIZE_W-1:0]  host_size,
    input logic [NUM_WIN-1:0] tgt_sel,
    input logic               tgt_we,
    input logic [BYTES-1:0]   tgt_bmask,
    input logic               rsp_valid,
    input logic               rsp_err,
    input logic [DATA_W-1:0]  rsp_rdata
);

    logic size_legal;
    assign size_legal = (host_size == SZ_BYTE) || (host_size == SZ_WORD);

    p_sel_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tgt_sel));

    p_idle_no_sel_r2: assert property (@(posedge clk) disable iff (rst)
        !host_req |-> (tgt_sel == '0) && !tgt_we);

    p_bad_size_no_sel_r4: assert property (@(posedge clk) disable iff (rst)
        (host_req && !size_legal) |-> (tgt_sel == '0) && !tgt_we);

    p_bad_size_reply_r4: assert property (@(posedge clk) disable iff (rst)
        (host_req && !size_legal) |=> rsp_err && (rsp_rdata == '0));

    p_unmapped_reply_r5: assert property (@(posedge clk) disable iff (rst)
        (host_req && size_legal && tgt_sel == '0) |=> rsp_err && (rsp_rdata == '1));

    p_byte_one_lane_r6: assert property (@(posedge clk) disable iff (rst)
        (tgt_sel != '0 && host_size == SZ_BYTE) |-> $countones(tgt_bmask) == 1);

    p_word_all_lanes_r8: assert property (@(posedge clk) disable iff (rst)
        (tgt_sel != '0 && host_size == SZ_WORD) |-> tgt_bmask == '1);

    p_reply_follows_r9: assert property (@(posedge clk) disable iff (rst)
        host_req |=> rsp_valid);

    p_no_spurious_reply_r9: assert property (@(posedge clk) disable iff (rst)
        !host_req |=> !rsp_valid && !rsp_err);

    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> !rsp_valid && !rsp_err && (rsp_rdata == '0));

endmodule

bind opb_window_router opbr_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .host_req  (host_req),
    .host_size (host_size),
    .tgt_sel   (tgt_sel),
    .tgt_we    (tgt_we),
    .tgt_bmask (tgt_bmask),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata)
);

// File: tb/tb_opb_window_router.sv
`timescale 1ns/1ps
module tb_opb_window_router;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         host_req = 1'b0;
    logic         host_we = 1'b0;
    logic [63:0]  host_addr = '0;
    logic [3:0]   host_size = '0;
    logic [31:0]  host_wdata = '0;
    logic [5:0]   tgt_sel;
    logic         tgt_we;
    logic [31:0]  tgt_offset;
    logic [3:0]   tgt_bmask;
    logic [31:0]  tgt_wdata;
    logic [191:0] tgt_rdata;
    logic         rsp_valid;
    logic         rsp_err;
    logic [31:0]  rsp_rdata;

    always #10 clk = ~clk;

    opb_window_router dut (
        .clk        (clk),
        .rst        (rst),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_size  (host_size),
        .host_wdata (host_wdata),
        .tgt_sel    (tgt_sel),
        .tgt_we     (tgt_we),
        .tgt_offset (tgt_offset),
        .tgt_bmask  (tgt_bmask),
        .tgt_wdata  (tgt_wdata),
        .tgt_rdata  (tgt_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err),
        .rsp_rdata  (rsp_rdata)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string force_tag = "";

    // Reference window table: inclusive first and last byte of each window.
    function automatic int model_win(input logic [31:0] a);
        if (a >= 32'hC001_0000 && a <= 32'hC001_005F) return 3;
        if (a >= 32'hC001_1000 && a <= 32'hC001_1007) return 4;
        if (a >= 32'hC001_2000 && a <= 32'hC001_20FF) return 5;
        if (a >= 32'hD001_0000 && a <= 32'hD001_FFFF) return 0;
        if (a >= 32'hE001_0000 && a <= 32'hEFFF_FFFF) return 1;
        if (a >= 32'hF000_0000)                       return 2;
        return -1;
    endfunction

    function automatic logic [31:0] model_first(input int w);
        logic [31:0] f [6] = '{32'hD001_0000, 32'hE001_0000, 32'hF000_0000,
                               32'hC001_0000, 32'hC001_1000, 32'hC001_2000};
        return f[w];
    endfunction

    function automatic logic [31:0] model_len(input int w);
        logic [31:0] l [6] = '{32'h1_0000, 32'h0FFF_0000, 32'h1000_0000,
                               32'h60, 32'h8, 32'h100};
        return l[w];
    endfunction

    // Byte at address offset b of target w is {w+1, b}; word is big-endian.
    function automatic logic [31:0] pat_word(input int w);
        logic [31:0] r = '0;
        for (int b = 0; b < 4; b++) r = (r << 8) | 32'((w + 1) * 16 + b);
        return r;
    endfunction

    for (genvar gw = 0; gw < 6; gw++) begin : g_tgt
        assign tgt_rdata[32*gw +: 32] = pat_word(gw);
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic        p_v = 1'b0;
    logic        p_err = 1'b0;
    logic [31:0] p_rd = '0;
    string       p_tag = "R10";

    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [31:0] a;
            int          w;
            bit          szok;
            int          k;
            logic [5:0]  e_sel;
            string       st;

            chk("R9 rsp_valid", rsp_valid, p_v);
            chk({p_tag, " rsp_err"}, rsp_err, p_err);
            chk({p_tag, " rsp_rdata"}, rsp_rdata, p_rd);

            a    = host_addr[31:0];
            w    = model_win(a);
            szok = (host_size == 4'd1) || (host_size == 4'd4);
            k    = int'(a[1:0]);
            e_sel = (host_req && szok && w >= 0) ? 6'(1 << w) : 6'd0;

            if (!host_req)                st = "R2";
            else if (force_tag != "")     st = force_tag;
            else if (host_addr[63:32] != 0) st = "R1";
            else if (!szok)               st = "R4";
            else if (w < 0)               st = "R5";
            else                          st = "R2";

            chk({st, " tgt_sel"}, tgt_sel, e_sel);
            chk({st, " tgt_we"}, tgt_we, host_req && host_we && e_sel != 0);
            if (e_sel != 0) begin
                chk("R3 tgt_offset", tgt_offset, a - model_first(w));
                if (host_size == 4'd1) begin
                    chk("R6 tgt_bmask", tgt_bmask, 4'b0001 << (3 - k));
                    chk("R6 tgt_wdata", tgt_wdata, 32'(host_wdata[7:0]) << (8 * (3 - k)));
                end else begin
                    chk("R8 tgt_bmask", tgt_bmask, 4'hF);
                    chk("R8 tgt_wdata", tgt_wdata, host_wdata);
                end
            end

            if (!host_req) begin
                p_v = 1'b0; p_err = 1'b0; p_rd = '0; p_tag = "R9";
            end else begin
                p_v = 1'b1;
                if (!szok) begin
                    p_err = 1'b1; p_rd = '0; p_tag = "R4";
                end else if (w < 0) begin
                    p_err = 1'b1; p_rd = 32'hFFFF_FFFF; p_tag = "R5";
                end else if (host_we) begin
                    p_err = 1'b0; p_rd = '0; p_tag = "R8";
                end else if (host_size == 4'd1) begin
                    p_err = 1'b0; p_rd = 32'((w + 1) * 16 + k); p_tag = "R7";
                end else begin
                    p_err = 1'b0; p_rd = pat_word(w); p_tag = "R8";
                end
                if (force_tag != "") p_tag = force_tag;
                else if (host_addr[63:32] != 0) p_tag = "R1";
            end
        end
    end

    task automatic issue(input bit we, input logic [63:0] addr, input logic [3:0] sz,
                         input logic [31:0] wd, input string tag);
        @(posedge clk); #1;
        host_req = 1'b1; host_we = we; host_addr = addr;
        host_size = sz; host_wdata = wd; force_tag = tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            host_req = 1'b0; host_we = 1'b0; force_tag = "";
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 rsp_valid", rsp_valid, 1'b0);
        chk("R10 rsp_err", rsp_err, 1'b0);
        chk("R10 rsp_rdata", rsp_rdata, 32'h0);
        @(posedge clk); #1;
        rst = 1'b0;
        idle(2);

        for (int w = 0; w < 6; w++) issue(1'b0, 64'(model_first(w)), 4'd4, 32'h0, "R2");
        idle(1);
        issue(1'b0, 64'(model_first(0) + 32'h24), 4'd4, 32'h0, "R3");
        issue(1'b0, 64'(model_first(2) + 32'h0ABC_DEF0), 4'd4, 32'h0, "R3");
        for (int k = 0; k < 4; k++) issue(1'b0, 64'(model_first(1) + 32'h100 + 32'(k)), 4'd1, 32'h0, "R7");
        for (int k = 0; k < 4; k++) issue(1'b1, 64'(model_first(5) + 32'h10 + 32'(k)), 4'd1, 32'hFFFF_FF5A + 32'(k), "R6");
        issue(1'b1, 64'(model_first(3) + 32'h40), 4'd4, 32'h1234_5678, "R8");
        issue(1'b0, 64'(model_first(4) + 32'h4), 4'd4, 32'h0, "R8");
        idle(1);
        for (int s = 0; s < 16; s++) begin
            if (s != 1 && s != 4) issue(s[0], 64'(model_first(0)), 4'(s), 32'hCAFE_F00D, "R4");
        end
        issue(1'b0, 64'h0, 4'd2, 32'h0, "R4");
        issue(1'b1, 64'h0, 4'd1, 32'h11, "R5");
        issue(1'b0, 64'hC000_0000, 4'd4, 32'h0, "R5");
        issue(1'b0, 64'hE000_0000, 4'd4, 32'h0, "R5");
        issue(1'b0, 64'hC001_005F, 4'd1, 32'h0, "R11");
        issue(1'b0, 64'hC001_0060, 4'd1, 32'h0, "R11");
        issue(1'b0, 64'hC001_1007, 4'd1, 32'h0, "R11");
        issue(1'b0, 64'hC001_1008, 4'd1, 32'h0, "R11");
        issue(1'b0, 64'hC001_20FF, 4'd1, 32'h0, "R11");
        issue(1'b0, 64'hC001_2100, 4'd1, 32'h0, "R11");
        issue(1'b0, 64'hD001_FFFF, 4'd1, 32'h0, "R11");
        issue(1'b0, 64'hD002_0000, 4'd1, 32'h0, "R11");
        issue(1'b0, 64'hEFFF_FFFF, 4'd1, 32'h0, "R11");
        issue(1'b0, 64'hFFFF_FFFF, 4'd1, 32'h0, "R11");
        issue(1'b0, 64'hE001_0000 - 64'h1, 4'd1, 32'h0, "R11");
        issue(1'b0, 64'hDEAD_BEEF_C001_1004, 4'd4, 32'h0, "R1");
        issue(1'b0, 64'h0000_0001_0000_0000, 4'd4, 32'h0, "R1");
        issue(1'b1, 64'hFFFF_FFFF_D001_0002, 4'd1, 32'h77, "R1");
        idle(3);

        for (int n = 0; n < 400; n++) begin
            int          w;
            logic [31:0] off;
            logic [3:0]  sz;
            logic [3:0]  pick [7] = '{4'd1, 4'd4, 4'd1, 4'd4, 4'd2, 4'd0, 4'd3};
            w   = int'($urandom_range(0, 5));
            off = $urandom % (model_len(w) + 32'd16);
            sz  = pick[$urandom_range(0, 6)];
            if ($urandom_range(0, 7) == 0) idle(1);
            issue(1'($urandom), {32'($urandom_range(0, 3) == 0 ? $urandom : 0), model_first(w) + off},
                  sz, $urandom, "");
        end
        idle(3);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule